// File: doc/BRIEF.md
# ASID-Tagged Fully Associative Translation Buffer

This block turns a 32-bit virtual address into a physical address for a processor pipeline. The three top address bits pick one of four regions. Two regions are direct windows onto physical memory: one is cached and one is uncached, and neither uses the translation entries. The other two regions, a user region and a kernel virtual region, go through a 64-slot content-addressable store. Every slot compares its page number and its 6-bit address-space tag against the request in the same cycle. A slot marked global matches any address-space tag. Because each slot carries an address-space tag, a context switch only changes the tag driven on the lookup port. No entries have to be discarded.

A lookup whose request is present settles combinationally in the same cycle. It gives the physical address, an uncached flag, the stored referenced and dirty bits of the matching slot, and one of two error flags: miss or protection fault. On the clock edge that ends a successful lookup, the block sets the slot's referenced bit. A successful store also sets the slot's dirty bit. A store to a read-only slot raises a fault and leaves the slot unchanged.

Misses go to a software handler, which walks the page tables and refills a slot through the write port. The write port can target a slot chosen by the handler. It can also target the slot held by a down-counting replacement counter, which never selects the lowest wired slots.

Top module: `tlb_xlate`

## Requirements
- R1: While reset is applied, `rand_slot` equals 63. After reset, every slot is invalid, so any lookup in a translated region reports a miss.
- R2: A lookup in a translated region hits when a valid slot has an equal 20-bit page number (address bits 31:12) and an equal address-space tag. On a hit, `lk_paddr` is the slot's 20-bit frame followed by the 12 offset bits of the request, and `lk_miss` is 0.
- R3: A slot whose tag differs from the request does not hit, unless the slot is marked global.
- R4: A lookup with address bits 31:29 equal to 0xx (user region) or 11x (kernel virtual region) raises `lk_miss` when no valid slot matches. `lk_miss` and `lk_fault` are never high together.
- R5: Address bits 31:29 equal to 100 select the cached physical window. In this window `lk_paddr` is the virtual address with bits 31:29 cleared, `lk_uncached` is 0, and `lk_miss` and `lk_fault` are 0 whatever the slots hold.
- R6: Address bits 31:29 equal to 101 select the uncached physical window. The address mapping is the same as in R5, but `lk_uncached` is 1.
- R7: On a hit in a translated region, `lk_uncached` equals the no-cache bit of the matching slot.
- R8: A store (`lk_write`=1) that hits a slot whose writable bit is 0 raises `lk_fault`. It leaves that slot's dirty bit at its old value.
- R9: A lookup that hits without a fault sets the slot's referenced bit at the end of that cycle. `lk_ref` shows the stored value, so the next hit on that slot reads 1.
- R10: A store that hits a writable slot sets the slot's dirty bit at the end of that cycle. The next hit on that slot reads `lk_dirty`=1.
- R11: When `wr_en` is high, the slot given by `wr_index` is loaded at the clock edge. When `wr_use_rand` is also high, the slot given by `rand_slot` is loaded instead. A loaded slot has its referenced and dirty bits cleared.
- R12: `rand_slot` counts down by one each cycle from 63 to 8, then returns to 63. Random writes therefore never touch the wired slots 0 to 7.
- R13: When `lk_valid` is 0, `lk_miss` and `lk_fault` are 0, and the slots' referenced and dirty bits do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| lk_valid | input | 1 | Lookup request present |
| lk_vaddr | input | 32 | Virtual address of the request |
| lk_asid | input | 6 | Address-space tag of the current context |
| lk_write | input | 1 | Request is a store |
| lk_paddr | output | 32 | Physical address |
| lk_miss | output | 1 | No matching slot in a translated region |
| lk_fault | output | 1 | Store to a read-only slot |
| lk_uncached | output | 1 | Access must bypass the data cache |
| lk_ref | output | 1 | Stored referenced bit of the matching slot |
| lk_dirty | output | 1 | Stored dirty bit of the matching slot |
| wr_en | input | 1 | Load a slot at this clock edge |
| wr_use_rand | input | 1 | Target the replacement slot instead of `wr_index` |
| wr_index | input | 6 | Target slot for an indexed load |
| wr_vpn | input | 20 | Page number to store |
| wr_asid | input | 6 | Address-space tag to store |
| wr_global | input | 1 | Slot matches any tag |
| wr_pfn | input | 20 | Physical frame to store |
| wr_writable | input | 1 | Stores are allowed |
| wr_nocache | input | 1 | Accesses through this slot are uncached |
| wr_valid | input | 1 | Slot is valid |
| rand_slot | output | 6 | Current replacement slot |

## Verification
The assertions check the following on every cycle:
- the physical windows never miss or fault;
- miss and fault are never high together;
- an idle port raises no error;
- the replacement counter stays at or above the wired floor, and each step moves it down by one;
- per slot, the referenced and dirty bits are set after a successful access, and the dirty bit is held after a faulting store.

Only the bench scenarios can show the following:
- the address-space matching rules, including the global override;
- the exact translated and window addresses;
- the uncached flag taken from a slot;
- that random refills leave wired slots intact;
- that a fresh reset discards earlier entries.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  parameter int VA_W   = 32;
  parameter int OFF_W  = 12;
  parameter int ASID_W = 6;
  parameter int PFN_W  = 20;
  parameter int SEG_W  = 3;
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PA_W  = PFN_W + OFF_W;

  typedef enum logic [1:0] {
    SEG_USER  = 2'd0,
    SEG_PHYS  = 2'd1,
    SEG_PHYSU = 2'd2,
    SEG_KVIRT = 2'd3
  } seg_e;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic              glob;
    logic [PFN_W-1:0]  pfn;
    logic              wrable;
    logic              nocache;
  } tag_t;
endpackage

// File: rtl/tlb_seg_decode.sv
module tlb_seg_decode
  import tlb_pkg::*;
(
  input  logic [SEG_W-1:0] top_bits,
  output seg_e             seg,
  output logic             translated
);
  always_comb begin
    if (!top_bits[2])      seg = SEG_USER;
    else if (top_bits[1])  seg = SEG_KVIRT;
    else if (top_bits[0])  seg = SEG_PHYSU;
    else                   seg = SEG_PHYS;
    translated = (seg == SEG_USER) || (seg == SEG_KVIRT);
  end
endmodule

// File: rtl/tlb_rand_idx.sv
module tlb_rand_idx #(
  parameter int N_ENT = 64,
  parameter int WIRED = 8,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [IDX_W-1:0] slot
);
  logic [IDX_W-1:0] slot_d;

  always_comb begin
    if (slot == IDX_W'(WIRED)) slot_d = IDX_W'(N_ENT - 1);
    else                       slot_d = slot - IDX_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot <= IDX_W'(N_ENT - 1);
    else        slot <= slot_d;
  end

  p_rand_floor_r12: assert property (@(posedge clk) disable iff (!rst_n)
    slot >= IDX_W'(WIRED));
  p_rand_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (slot != IDX_W'(WIRED)) |=> (slot == $past(slot) - IDX_W'(1)));
endmodule

// File: rtl/tlb_cam.sv
module tlb_cam
  import tlb_pkg::*;
#(
  parameter int N_ENT = 64,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_en,
  input  logic              lk_write,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              hit,
  output logic              fault,
  output logic [PFN_W-1:0]  hit_pfn,
  output logic              hit_nocache,
  output logic              hit_ref,
  output logic              hit_dirty,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  tag_t              wr_tag,
  input  logic              wr_vld
);
  tag_t             data_q [N_ENT];
  logic [N_ENT-1:0] vld_q, ref_q, dirty_q;
  logic [N_ENT-1:0] vld_d, ref_d, dirty_d;
  logic [N_ENT-1:0] match, wr_hit;
  logic [IDX_W-1:0] hit_idx;
  logic             upd_go;
  tag_t             sel;

  for (genvar gi = 0; gi < N_ENT; gi++) begin : g_cmp
    assign match[gi] = vld_q[gi] && (data_q[gi].vpn == lk_vpn) &&
                       (data_q[gi].glob || (data_q[gi].asid == lk_asid));
    assign wr_hit[gi] = wr_en && (wr_idx == IDX_W'(gi));
  end

  always_comb begin
    hit_idx = '0;
    for (int i = N_ENT - 1; i >= 0; i--)
      if (match[i]) hit_idx = IDX_W'(i);
  end

  assign sel         = data_q[hit_idx];
  assign hit         = lk_en && (|match);
  assign fault       = hit && lk_write && !sel.wrable;
  assign upd_go      = hit && !fault;
  assign hit_pfn     = sel.pfn;
  assign hit_nocache = sel.nocache;
  assign hit_ref     = ref_q[hit_idx];
  assign hit_dirty   = dirty_q[hit_idx];

  always_comb begin
    vld_d   = vld_q;
    ref_d   = ref_q;
    dirty_d = dirty_q;
    for (int i = 0; i < N_ENT; i++) begin
      if (wr_hit[i]) begin
        vld_d[i]   = wr_vld;
        ref_d[i]   = 1'b0;
        dirty_d[i] = 1'b0;
      end else if (upd_go && (hit_idx == IDX_W'(i))) begin
        ref_d[i] = 1'b1;
        if (lk_write) dirty_d[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= '0;
      ref_q   <= '0;
      dirty_q <= '0;
    end else begin
      vld_q   <= vld_d;
      ref_q   <= ref_d;
      dirty_q <= dirty_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) data_q[wr_idx] <= wr_tag;
  end

  for (genvar gi = 0; gi < N_ENT; gi++) begin : g_chk
    p_ref_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_go && hit_idx == IDX_W'(gi) && !wr_hit[gi]) |=> ref_q[gi]);
    p_dirty_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_go && lk_write && hit_idx == IDX_W'(gi) && !wr_hit[gi]) |=> dirty_q[gi]);
    p_fault_keeps_dirty_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (fault && hit_idx == IDX_W'(gi) && !wr_hit[gi]) |=> (dirty_q[gi] == $past(dirty_q[gi])));
  end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int N_ENT = 64,
  parameter int WIRED = 8,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              lk_write,
  output logic [PA_W-1:0]   lk_paddr,
  output logic              lk_miss,
  output logic              lk_fault,
  output logic              lk_uncached,
  output logic              lk_ref,
  output logic              lk_dirty,
  input  logic              wr_en,
  input  logic              wr_use_rand,
  input  logic [IDX_W-1:0]  wr_index,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_global,
  input  logic [PFN_W-1:0]  wr_pfn,
  input  logic              wr_writable,
  input  logic              wr_nocache,
  input  logic              wr_valid,
  output logic [IDX_W-1:0]  rand_slot
);
  logic [1:0]       rst_q;
  logic             rst_n_s;
  seg_e             seg;
  logic             translated;
  logic             hit, fault;
  logic [PFN_W-1:0] hit_pfn;
  logic             hit_nocache, hit_ref, hit_dirty;
  logic [IDX_W-1:0] wr_slot;
  tag_t             wr_tag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_n_s = rst_q[1];

  tlb_seg_decode u_seg (
    .top_bits   (lk_vaddr[VA_W-1 -: SEG_W]),
    .seg        (seg),
    .translated (translated)
  );

  tlb_rand_idx #(.N_ENT(N_ENT), .WIRED(WIRED)) u_rand (
    .clk   (clk),
    .rst_n (rst_n_s),
    .slot  (rand_slot)
  );

  assign wr_slot = wr_use_rand ? rand_slot : wr_index;
  assign wr_tag  = '{vpn: wr_vpn, asid: wr_asid, glob: wr_global, pfn: wr_pfn,
                     wrable: wr_writable, nocache: wr_nocache};

  tlb_cam #(.N_ENT(N_ENT)) u_cam (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .lk_en       (lk_valid && translated),
    .lk_write    (lk_write),
    .lk_vpn      (lk_vaddr[VA_W-1:OFF_W]),
    .lk_asid     (lk_asid),
    .hit         (hit),
    .fault       (fault),
    .hit_pfn     (hit_pfn),
    .hit_nocache (hit_nocache),
    .hit_ref     (hit_ref),
    .hit_dirty   (hit_dirty),
    .wr_en       (wr_en),
    .wr_idx      (wr_slot),
    .wr_tag      (wr_tag),
    .wr_vld      (wr_valid)
  );

  always_comb begin
    lk_paddr    = {{SEG_W{1'b0}}, lk_vaddr[VA_W-SEG_W-1:0]};
    lk_uncached = (seg == SEG_PHYSU);
    lk_miss     = 1'b0;
    lk_fault    = 1'b0;
    lk_ref      = 1'b0;
    lk_dirty    = 1'b0;
    if (translated) begin
      lk_paddr    = {hit_pfn, lk_vaddr[OFF_W-1:0]};
      lk_uncached = hit && hit_nocache;
      lk_miss     = lk_valid && !hit;
      lk_fault    = fault;
      lk_ref      = hit && hit_ref;
      lk_dirty    = hit && hit_dirty;
    end
  end

  p_window_no_error_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (lk_valid && lk_vaddr[VA_W-1 -: 2] == 2'b10) |-> (!lk_miss && !lk_fault));
  p_miss_fault_excl_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(lk_miss && lk_fault));
  p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n_s)
    !lk_valid |-> (!lk_miss && !lk_fault));
endmodule

// File: tb/test_tlb_xlate.sv
module test_tlb_xlate;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid, lk_write;
  logic [31:0] lk_vaddr;
  logic [5:0]  lk_asid;
  logic [31:0] lk_paddr;
  logic        lk_miss, lk_fault, lk_uncached, lk_ref, lk_dirty;
  logic        wr_en, wr_use_rand, wr_global, wr_writable, wr_nocache, wr_valid;
  logic [5:0]  wr_index, wr_asid, rand_slot;
  logic [19:0] wr_vpn, wr_pfn;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  tlb_xlate i_tlb_xlate (.*);

  // {vaddr, asid(8), miss(4), uncached(4), paddr}
  localparam logic [79:0] VEC [10] = '{
    {32'h0001_0123, 8'h05, 4'h0, 4'h0, 32'hABCD_E123},  // R2 user hit
    {32'h0001_0123, 8'h06, 4'h1, 4'h0, 32'h0},          // R3 tag mismatch
    {32'h0003_0456, 8'h02, 4'h0, 4'h0, 32'h0F0F_0456},  // R3 global slot
    {32'h0002_0FFF, 8'h05, 4'h0, 4'h1, 32'h1234_5FFF},  // R7 no-cache slot
    {32'h0004_0000, 8'h05, 4'h1, 4'h0, 32'h0},          // R4 invalid slot
    {32'hE000_1ABC, 8'h05, 4'h0, 4'h0, 32'h0077_7ABC},  // R2 kernel virtual
    {32'hE000_2000, 8'h05, 4'h1, 4'h0, 32'h0},          // R4 kernel virtual miss
    {32'h8000_1234, 8'h05, 4'h0, 4'h0, 32'h0000_1234},  // R5 cached window
    {32'hBFFF_FFFF, 8'h3F, 4'h0, 4'h1, 32'h1FFF_FFFF},  // R6 uncached window
    {32'h9000_0000, 8'h00, 4'h0, 4'h0, 32'h1000_0000}   // R5 cached window
  };

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input int idx, input logic rnd, input logic [19:0] vpn, input logic [5:0] asid,
                     input logic glob, input logic [19:0] pfn, input logic wra, input logic nc,
                     input logic vld);
    @(negedge clk);
    wr_en = 1'b1; wr_use_rand = rnd; wr_index = 6'(idx); wr_vpn = vpn; wr_asid = asid;
    wr_global = glob; wr_pfn = pfn; wr_writable = wra; wr_nocache = nc; wr_valid = vld;
    @(negedge clk);
    wr_en = 1'b0; wr_use_rand = 1'b0;
  endtask

  task automatic look(input logic [31:0] va, input logic [5:0] asid, input logic wr);
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = va; lk_asid = asid; lk_write = wr;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    lk_valid = 1'b0; lk_write = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [5:0] prev;
    rst_n = 1'b0; lk_valid = 0; lk_write = 0; lk_vaddr = '0; lk_asid = '0;
    wr_en = 0; wr_use_rand = 0; wr_index = '0; wr_vpn = '0; wr_asid = '0;
    wr_global = 0; wr_pfn = '0; wr_writable = 0; wr_nocache = 0; wr_valid = 0;
    repeat (3) @(negedge clk);
    chk(rand_slot == 6'd63, "R1 rand_slot in reset", 32'(rand_slot), 32'd63);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    look(32'h0001_0123, 6'd5, 1'b0);
    chk(lk_miss, "R1 empty after reset", 32'(lk_miss), 32'd1);
    idle();

    put(0, 0, 20'h00010, 6'd5, 0, 20'hABCDE, 1, 0, 1);
    put(1, 0, 20'h00020, 6'd5, 0, 20'h12345, 0, 1, 1);
    put(2, 0, 20'h00030, 6'd9, 1, 20'h0F0F0, 1, 0, 1);
    put(3, 0, 20'hE0001, 6'd5, 0, 20'h00777, 1, 0, 1);
    put(4, 0, 20'h00040, 6'd5, 0, 20'h44444, 1, 0, 0);

    for (int k = 0; k < 10; k++) begin
      look(VEC[k][79:48], VEC[k][45:40], 1'b0);
      chk(lk_miss == VEC[k][36] && !lk_fault, "R2-table miss/fault", 32'(lk_miss), 32'(VEC[k][36]));
      if (!VEC[k][36]) begin
        chk(lk_paddr == VEC[k][31:0], "R2 paddr", lk_paddr, VEC[k][31:0]);
        chk(lk_uncached == VEC[k][32], "R7 uncached", 32'(lk_uncached), 32'(VEC[k][32]));
      end
    end
    idle();

    // R9 / R10 referenced and dirty tracking
    put(5, 0, 20'h00050, 6'd5, 0, 20'h55555, 1, 0, 1);
    look(32'h0005_0000, 6'd5, 1'b0);
    chk(!lk_ref && !lk_dirty, "R9 fresh slot ref clear", 32'(lk_ref), 32'd0);
    look(32'h0005_0004, 6'd5, 1'b0);
    chk(lk_ref, "R9 ref set after hit", 32'(lk_ref), 32'd1);
    chk(!lk_dirty, "R10 read leaves dirty", 32'(lk_dirty), 32'd0);
    look(32'h0005_0008, 6'd5, 1'b1);
    chk(!lk_fault && !lk_miss, "R10 store to writable", 32'(lk_fault), 32'd0);
    look(32'h0005_0008, 6'd5, 1'b0);
    chk(lk_dirty, "R10 dirty set after store", 32'(lk_dirty), 32'd1);

    // R8 read-only slot
    look(32'h0002_0010, 6'd5, 1'b1);
    chk(lk_fault && !lk_miss, "R8 fault on read-only store", 32'(lk_fault), 32'd1);
    look(32'h0002_0010, 6'd5, 1'b0);
    chk(!lk_dirty && !lk_fault, "R8 dirty unchanged", 32'(lk_dirty), 32'd0);

    // R13 idle port
    @(negedge clk);
    lk_valid = 1'b0; lk_vaddr = 32'h0006_0000; lk_write = 1'b1; #1;
    chk(!lk_miss && !lk_fault, "R13 idle quiet", 32'(lk_miss), 32'd0);
    @(negedge clk);
    lk_write = 1'b0;
    look(32'h0005_0000, 6'd5, 1'b0);
    chk(lk_ref && lk_dirty, "R13 idle left slot bits", 32'({lk_ref, lk_dirty}), 32'd3);
    idle();

    // R12 counter sequence
    prev = rand_slot;
    for (int k = 0; k < 70; k++) begin
      @(negedge clk);
      chk(rand_slot == ((prev == 6'd8) ? 6'd63 : prev - 6'd1), "R12 rand step",
          32'(rand_slot), 32'((prev == 6'd8) ? 6'd63 : prev - 6'd1));
      prev = rand_slot;
    end

    // R11 / R12 random refills spare wired slots
    for (int k = 0; k < 60; k++)
      put(0, 1, 20'h30000 + 20'(k), 6'd5, 0, 20'h60000 + 20'(k), 1, 0, 1);
    look(32'h3003_B000, 6'd5, 1'b0);
    chk(!lk_miss && lk_paddr == 32'h6003_B000, "R11 random refill hit", lk_paddr, 32'h6003_B000);
    look(32'h0001_0000, 6'd5, 1'b0);
    chk(!lk_miss, "R12 wired slot 0 kept", 32'(lk_miss), 32'd0);
    look(32'hE000_1000, 6'd5, 1'b0);
    chk(!lk_miss && lk_paddr == 32'h0077_7000, "R12 wired slot 3 kept", lk_paddr, 32'h0077_7000);

    // R11 indexed overwrite
    put(0, 0, 20'h00070, 6'd5, 0, 20'h77777, 1, 0, 1);
    look(32'h0001_0000, 6'd5, 1'b0);
    chk(lk_miss, "R11 old mapping replaced", 32'(lk_miss), 32'd1);
    look(32'h0007_0ABC, 6'd5, 1'b0);
    chk(!lk_miss && lk_paddr == 32'h7777_7ABC && !lk_ref, "R11 new mapping", lk_paddr, 32'h7777_7ABC);
    idle();

    // R1 reset again discards entries
    rst_n = 1'b0;
    @(negedge clk);
    chk(rand_slot == 6'd63, "R1 rand_slot reset again", 32'(rand_slot), 32'd63);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    look(32'h0007_0ABC, 6'd5, 1'b0);
    chk(lk_miss, "R1 entries invalid after reset", 32'(lk_miss), 32'd1);
    idle();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule